// File: doc/BRIEF.md
# Held-Serial-Clock Synchronize and Power-Down Detector

This block watches the serial clock of a converter's read port. In normal use that clock rests low between reads. A controller signals a special request by keeping it high over whole conversion frames. The frame boundaries reach the block as a single-cycle `frame_tick` in the system clock domain. The serial clock is asynchronous to that domain, so it passes through a synchronizer chain first.

Once the serial clock has stayed high through a run of complete frames, the block does three things. It takes over the shared ready/data pin, drives that pin low for a few system clocks, and then drives it high. It also holds the modulator in reset, which lets several converters line up on one common release. If the clock stays high for a longer run of frames, the block also requests power-down. A falling edge of the serial clock ends either condition. All outputs drop and frame counting starts over, so the next ready pulse from the converter marks fresh data.

Top module: `sclk_hold_monitor`

## Requirements
- R1: While `rst_n` is low and after reset, `rdy_force`, `rdy_level`, `mod_reset` and `power_down` are all 0.
- R2: Counting starts at the first `frame_tick` seen with the synchronized serial clock high; that tick opens a frame but does not count it. At the tick that closes the SYNC_FRAMES-th (default 4) complete high frame, `mod_reset` rises. No earlier tick raises it.
- R3: When `mod_reset` rises, `rdy_force`=1 and `rdy_level`=0 for exactly PULSE_CLKS (default 3) clock cycles.
- R4: After that low pulse, and while the hold lasts, `rdy_force`=1, `rdy_level`=1 and `mod_reset`=1.
- R5: Any cycle in which the synchronized serial clock is low clears the frame count. This includes a low lasting a single clock. Counting then restarts as in R2.
- R6: A falling edge of `sclk_in` releases the block from the low pulse, the hold or power-down. All four outputs are 0 after the third rising clock edge that samples the low level. Release takes priority over every other transition.
- R7: While no hold is active, ticks with the serial clock low and short high levels that end before the count completes leave all outputs at 0.
- R8: At the tick that closes the PDOWN_FRAMES-th (default 20) complete high frame, `power_down` rises. `mod_reset`, `rdy_force` and `rdy_level` stay at 1. No earlier tick raises it.
- R9: After a release the count starts at zero. A new hold needs SYNC_FRAMES fresh complete frames.
- R10: Once entered, power-down persists through further high frames until a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial clock from the reader, asynchronous |
| frame_tick | input | 1 | One-cycle strobe at each conversion frame boundary |
| rdy_force | output | 1 | 1: the ready/data pin is driven from `rdy_level` |
| rdy_level | output | 1 | Level forced onto the ready/data pin |
| mod_reset | output | 1 | Holds the modulator in reset |
| power_down | output | 1 | Requests power-down |

## Verification
A frame count that is off by one shows up at the ports as `mod_reset` or `power_down` rising one frame early or late. This is caught at that very tick. A count that fails to clear on a brief low lets a later run trigger too soon, and a glitch scenario exposes that within four frames. A wrong mode register shows at once as a wrong pin-override pattern: a low pulse of the wrong length, a missing high hold, or a release that arrives too early or too late relative to the third clock edge after the serial clock falls.

// File: rtl/sclk_hold_monitor.sv
module sclk_hold_monitor #(
  parameter int SYNC_FRAMES  = 4,
  parameter int PDOWN_FRAMES = 20,
  parameter int PULSE_CLKS   = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic frame_tick,
  output logic rdy_force,
  output logic rdy_level,
  output logic mod_reset,
  output logic power_down
);

  localparam int CW = $clog2(PDOWN_FRAMES + 1);
  localparam int PW = $clog2(PULSE_CLKS + 1);
  localparam logic [CW-1:0] SYNC_N  = CW'(SYNC_FRAMES);
  localparam logic [CW-1:0] PDOWN_N = CW'(PDOWN_FRAMES);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_CLKS - 1);

  typedef enum logic [1:0] {M_RUN, M_PULSE, M_HOLD, M_OFF} mode_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s_hi, s_prev, fall;
  logic                   armed, armed_nxt;
  logic [CW-1:0]          cnt, cnt_nxt;
  logic [PW-1:0]          pcnt, pcnt_nxt;
  mode_t                  mode, mode_nxt;

  assign s_hi = sync_q[SYNC_STAGES-1];
  assign fall = s_prev & ~s_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      s_prev <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_in};
      s_prev <= s_hi;
    end
  end

  always_comb begin
    armed_nxt = armed;
    cnt_nxt   = cnt;
    if (!s_hi) begin
      armed_nxt = 1'b0;
      cnt_nxt   = '0;
    end else if (frame_tick) begin
      armed_nxt = 1'b1;
      if (armed && cnt != PDOWN_N) cnt_nxt = cnt + 1'b1;
    end
  end

  always_comb begin
    mode_nxt = mode;
    pcnt_nxt = pcnt;
    unique case (mode)
      M_RUN: if (cnt_nxt == SYNC_N) begin
        mode_nxt = M_PULSE;
        pcnt_nxt = '0;
      end
      M_PULSE:
        if (fall) mode_nxt = M_RUN;
        else if (pcnt == PULSE_LAST) mode_nxt = M_HOLD;
        else pcnt_nxt = pcnt + 1'b1;
      M_HOLD:
        if (fall) mode_nxt = M_RUN;
        else if (cnt_nxt == PDOWN_N) mode_nxt = M_OFF;
      M_OFF:
        if (fall) mode_nxt = M_RUN;
      default: mode_nxt = M_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      pcnt  <= '0;
      mode  <= M_RUN;
    end else begin
      armed <= armed_nxt;
      cnt   <= cnt_nxt;
      pcnt  <= pcnt_nxt;
      mode  <= mode_nxt;
    end
  end

  assign rdy_force  = (mode != M_RUN);
  assign rdy_level  = (mode == M_HOLD) || (mode == M_OFF);
  assign mod_reset  = (mode != M_RUN);
  assign power_down = (mode == M_OFF);

endmodule

// File: rtl/sclk_hold_monitor_chk.sv
module sclk_hold_monitor_chk #(
  parameter int PULSE_CLKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic sclk_in,
  input logic rdy_force,
  input logic rdy_level,
  input logic mod_reset,
  input logic power_down
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (rdy_force && !rdy_level) begin
      if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
    end else low_run <= '0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_reset |-> (!rdy_force && !rdy_level && !power_down));

  // R3
  pulse_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_reset) |-> (rdy_force && !rdy_level));

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 16'(PULSE_CLKS));

  // R4
  hold_forces_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_reset |-> rdy_force);

  // R8
  pdown_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_down) |-> ($past(rdy_level) && mod_reset));

  // R6
  release_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_reset) |-> !$past(sclk_in, 2));

endmodule

bind sclk_hold_monitor sclk_hold_monitor_chk #(.PULSE_CLKS(PULSE_CLKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .rdy_force(rdy_force),
  .rdy_level(rdy_level), .mod_reset(mod_reset), .power_down(power_down)
);

// File: tb/sclk_hold_monitor_test.sv
module sclk_hold_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 4;

  localparam logic [3:0] E_IDLE  = 4'b0000;
  localparam logic [3:0] E_PULSE = 4'b1010;
  localparam logic [3:0] E_HOLD  = 4'b1110;
  localparam logic [3:0] E_OFF   = 4'b1111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_in = 1'b0;
  logic frame_tick = 1'b0;
  logic rdy_force, rdy_level, mod_reset, power_down;

  typedef struct {
    int unsigned due;
    logic [3:0]  ex;
    string       tag;
  } item_t;

  item_t q[$];
  int unsigned cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  sclk_hold_monitor uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .frame_tick(frame_tick),
    .rdy_force(rdy_force), .rdy_level(rdy_level),
    .mod_reset(mod_reset), .power_down(power_down)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [3:0] act;
      it = q.pop_front();
      act = {rdy_force, rdy_level, mod_reset, power_down};
      compared++;
      if (act !== it.ex) begin
        mismatched++;
        $display("FAIL %s cycle %0d: actual %b expected %b", it.tag, cyc, act, it.ex);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic step(input logic sc, input logic tk, input logic [3:0] ex, input string tag);
    item_t it;
    @(negedge clk);
    sclk_in = sc;
    frame_tick = tk;
    it.due = cyc + 1;
    it.ex = ex;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic frames(input int n, input logic [3:0] ex, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b1, ex, tag);
      for (int j = 1; j < FRAME; j++) step(1'b1, 1'b0, ex, tag);
    end
  endtask

  task automatic raise(input string tag);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, E_IDLE, tag);
  endtask

  task automatic enter_hold(input string tag);
    step(1'b1, 1'b1, E_PULSE, tag);
    step(1'b1, 1'b0, E_PULSE, "R3 pulse");
    step(1'b1, 1'b0, E_PULSE, "R3 pulse");
    step(1'b1, 1'b0, E_HOLD, "R4 hold");
  endtask

  task automatic release_from(input logic [3:0] cur);
    step(1'b0, 1'b0, cur, "R6 latency");
    step(1'b0, 1'b0, cur, "R6 latency");
    step(1'b0, 1'b0, E_IDLE, "R6 release");
    step(1'b0, 1'b0, E_IDLE, "R6 stays released");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if ({rdy_force, rdy_level, mod_reset, power_down} !== E_IDLE) begin
      mismatched++;
      $display("FAIL R1 in reset: actual %b expected %b",
               {rdy_force, rdy_level, mod_reset, power_down}, E_IDLE);
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, E_IDLE, "R1 after reset");

    // R2 / R3 / R4 basic detection, then R6 release from hold
    raise("R7 high no ticks");
    frames(4, E_IDLE, "R2 no early hold");
    enter_hold("R2 hold on fourth full frame");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, E_HOLD, "R4 hold");
    release_from(E_HOLD);

    // R7 ticks with clock low, short high level
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b1, E_IDLE, "R7 low ticks");
      step(1'b0, 1'b0, E_IDLE, "R7 low ticks");
    end
    raise("R7 short high");
    frames(2, E_IDLE, "R7 short high");
    step(1'b0, 1'b0, E_IDLE, "R7 fall in idle");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, E_IDLE, "R7 fall in idle");

    // R5 one-cycle glitch clears the count
    raise("R5 rise");
    frames(4, E_IDLE, "R5 before glitch");
    step(1'b0, 1'b0, E_IDLE, "R5 glitch");
    raise("R5 rise again");
    frames(4, E_IDLE, "R5 count restarted");
    enter_hold("R5 hold after fresh count");

    // R8 power-down at twentieth full frame, R10 persistence
    step(1'b1, 1'b1, E_HOLD, "R8 no early power-down");
    for (int j = 1; j < FRAME; j++) step(1'b1, 1'b0, E_HOLD, "R8 no early power-down");
    frames(14, E_HOLD, "R8 no early power-down");
    step(1'b1, 1'b1, E_OFF, "R8 power-down");
    for (int j = 1; j < FRAME; j++) step(1'b1, 1'b0, E_OFF, "R10 stays off");
    frames(3, E_OFF, "R10 stays off");
    release_from(E_OFF);

    // R9 count restarts after release
    raise("R9 rise");
    frames(4, E_IDLE, "R9 fresh count");
    enter_hold("R9 hold again");
    release_from(E_HOLD);

    // R6 release during the low pulse
    raise("R6 rise");
    frames(4, E_IDLE, "R6 setup");
    step(1'b1, 1'b1, E_PULSE, "R2 hold");
    step(1'b0, 1'b0, E_PULSE, "R3 pulse");
    step(1'b0, 1'b0, E_PULSE, "R3 pulse");
    step(1'b0, 1'b0, E_IDLE, "R6 release in pulse");
    step(1'b0, 1'b0, E_IDLE, "R6 no hold after release");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule